// File: doc/BRIEF.md
# Two-Channel DAC Wake-Up Settling Timer

This block keeps track of whether each of two converter channels is powered or powered down. After a channel is brought back into service it raises a per-channel busy flag for as long as the output needs to settle. It is driven by single-cycle event pulses from a command decoder. A power-down pulse sends a channel to sleep. An update pulse wakes a sleeping channel. The block also drives a bias-enable output for the shared bias circuit, which is switched off only while both channels sleep.

The settling time depends on the state the channels were in before the wake. If the other channel was still running, the shared bias was still on and the short delay applies. If both channels were asleep, the bias has to restart as well. That needs a longer delay, and its length depends on a supply-select input (low selects the 5 V setting, high selects 3 V). All delays are given in microseconds and turned into clock cycles through the `CYC_PER_US` parameter. Stored register contents are outside this block: power-down only changes power state and busy timing.

Top module: `dac_wake_timer`

## Requirements
- R1: After reset both channels are powered, `busy` is 2'b00 and `bias_en` is 1.
- R2: A power-down pulse on one channel (bit 0 is channel A, bit 1 is channel B) puts only that channel to sleep. `bias_en` stays 1 while the other channel is powered.
- R3: `bias_en` is 0 from the cycle after the second channel goes to sleep, and only while both channels sleep.
- R4: An update pulse to a sleeping channel while the other channel is powered sets its busy bit from the next cycle for exactly SHORT_US*CYC_PER_US cycles.
- R5: An update pulse to a sleeping channel while both sleep, with `sup_3v`=0 at the pulse, keeps busy for exactly LONG5_US*CYC_PER_US cycles and sets `bias_en` to 1 from the next cycle.
- R6: The same wake with `sup_3v`=1 at the pulse keeps busy for exactly LONG3_US*CYC_PER_US cycles.
- R7: When both channels wake on the same pulse from the both-asleep state, both use the long delay and their busy bits fall on the same cycle.
- R8: An update pulse to a channel that is already powered has no effect. An idle channel stays not busy, and a counting channel keeps its remaining time.
- R9: A power-down pulse on a busy channel clears its busy bit on the next cycle and cancels its count.
- R10: When a power-down pulse and an update pulse reach the same channel in the same cycle, the update wins and the power-down is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_evt | input | 2 | Per-channel power-down pulse (bit 0 channel A) |
| upd_evt | input | 2 | Per-channel update / wake pulse |
| sup_3v | input | 1 | Supply select: 1 = 3 V setting, 0 = 5 V setting |
| busy | output | 2 | Per-channel not-yet-settled flag |
| bias_en | output | 1 | Shared bias enable, low only when both channels sleep |

## Verification
Busy pulse lengths are measured cycle by cycle under four wake patterns. A single wake with the partner awake distinguishes the short delay from the long ones. A single wake from the both-asleep state at each supply setting distinguishes the 12 µs delay from the 30 µs delay. A joint wake shows whether both channels take the long delay and finish together. Repeated updates in the middle of a count, a power-down in the middle of a count, and a power-down arriving together with an update show the priority and hold-off behaviour, because each of them would change a measured length or a flag sampled on the next cycle.

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
  parameter int CYC_PER_US = 250,
  parameter int SHORT_US   = 5,
  parameter int LONG5_US   = 12,
  parameter int LONG3_US   = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pd_evt,
  input  logic [1:0] upd_evt,
  input  logic       sup_3v,
  output logic [1:0] busy,
  output logic       bias_en
);
  localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int LONG5_CYC = LONG5_US * CYC_PER_US;
  localparam int LONG3_CYC = LONG3_US * CYC_PER_US;
  localparam int MAX_A     = (SHORT_CYC > LONG5_CYC) ? SHORT_CYC : LONG5_CYC;
  localparam int MAX_CYC   = (MAX_A > LONG3_CYC) ? MAX_A : LONG3_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  logic        asleep [2];
  logic        bz     [2];
  logic [CW-1:0] cnt  [2];

  wire          all_down = asleep[0] & asleep[1];
  wire [CW-1:0] long_ld  = sup_3v ? CW'(LONG3_CYC - 1) : CW'(LONG5_CYC - 1);
  wire [CW-1:0] load     = all_down ? long_ld : CW'(SHORT_CYC - 1);

  for (genvar i = 0; i < 2; i++) begin : g_ch
    wire wake = upd_evt[i] & asleep[i];
    wire nap  = pd_evt[i] & ~upd_evt[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        asleep[i] <= 1'b0;
        bz[i]     <= 1'b0;
        cnt[i]    <= '0;
      end else if (wake) begin
        asleep[i] <= 1'b0;
        bz[i]     <= 1'b1;
        cnt[i]    <= load;
      end else if (nap) begin
        asleep[i] <= 1'b1;
        bz[i]     <= 1'b0;
        cnt[i]    <= '0;
      end else if (bz[i]) begin
        if (cnt[i] == '0) bz[i] <= 1'b0;
        else              cnt[i] <= cnt[i] - 1'b1;
      end
    end

    assign busy[i] = bz[i];
  end

  assign bias_en = ~all_down;
endmodule

// File: rtl/dac_wake_timer_chk.sv
module dac_wake_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pd_evt,
  input logic [1:0] upd_evt,
  input logic       sup_3v,
  input logic [1:0] busy,
  input logic       bias_en
);
  p_pd_clears_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_evt[0] && !upd_evt[0]) |=> !busy[0]);
  p_pd_clears_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_evt[1] && !upd_evt[1]) |=> !busy[1]);
  p_rise_needs_upd_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[0]) |-> $past(upd_evt[0]));
  p_rise_needs_upd_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy[1]) |-> $past(upd_evt[1]));
  p_bias_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_evt == 2'b11 && upd_evt == 2'b00) |=> !bias_en);
  p_bias_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_en) |-> $past(|pd_evt));
  p_bias_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_evt) |=> bias_en);
endmodule

bind dac_wake_timer dac_wake_timer_chk u_chk (.*);

// File: tb/dac_wake_timer_tb.sv
module dac_wake_timer_tb;
  localparam int C = 250;
  logic clk = 1'b0, rst_n = 1'b0, sup_3v = 1'b0;
  logic [1:0] pd_evt = '0, upd_evt = '0, busy;
  logic bias_en;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dac_wake_timer #(.CYC_PER_US(C)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(logic [1:0] pd, logic [1:0] up);
    @(negedge clk); pd_evt = pd; upd_evt = up;
    @(negedge clk); pd_evt = '0; upd_evt = '0;
  endtask

  task automatic measure(int ch, output int n);
    n = 0;
    while (busy[ch] && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 bias_en", bias_en, 1);
  endtask

  task automatic t_pd_one;
    pulse(2'b01, 2'b00);
    chk("R2 bias_en one asleep", bias_en, 1);
    chk("R2 busy", busy, 0);
  endtask

  task automatic t_wake_short;
    int n;
    pulse(2'b00, 2'b01);
    measure(0, n);
    chk("R4 short delay", n, 5*C);
  endtask

  task automatic t_upd_awake;
    int n;
    pulse(2'b00, 2'b01);
    chk("R8 idle awake stays idle", busy, 0);
    pulse(2'b10, 2'b00);
    pulse(2'b00, 2'b10);
    repeat (100) @(negedge clk);
    pulse(2'b00, 2'b10);
    measure(1, n);
    chk("R8 count kept on repeat update", n + 102, 5*C);
  endtask

  task automatic t_long;
    int n0, n1;
    pulse(2'b11, 2'b00);
    chk("R3 bias off both asleep", bias_en, 0);
    sup_3v = 1'b0;
    pulse(2'b00, 2'b10);
    chk("R5 bias back on", bias_en, 1);
    measure(1, n1);
    chk("R5 long 5V delay", n1, 12*C);
    chk("R3 bias on one asleep", bias_en, 1);
    pulse(2'b10, 2'b00);
    chk("R3 bias off again", bias_en, 0);
    sup_3v = 1'b1;
    pulse(2'b00, 2'b11);
    sup_3v = 1'b0;
    n0 = 0; n1 = 0;
    while ((busy[0] || busy[1]) && n0 < 20000) begin
      if (busy[0]) n0++;
      if (busy[1]) n1++;
      @(negedge clk);
    end
    chk("R6 long 3V delay ch A", n0, 30*C);
    chk("R7 joint wake ch B", n1, 30*C);
  endtask

  task automatic t_cancel;
    pulse(2'b01, 2'b00);
    pulse(2'b00, 2'b01);
    repeat (100) @(negedge clk);
    chk("R9 busy before cancel", busy[0], 1);
    pulse(2'b01, 2'b00);
    chk("R9 busy cleared", busy[0], 0);
    repeat (5*C) @(negedge clk);
    chk("R9 stays clear", busy[0], 0);
  endtask

  task automatic t_same;
    int n;
    pulse(2'b01, 2'b01);
    measure(0, n);
    chk("R10 update wins", n, 5*C);
    chk("R10 bias on", bias_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pd_one;
    t_wake_short;
    t_upd_awake;
    t_long;
    t_cancel;
    t_same;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule